// File: doc/BRIEF.md
# Spindle Motor Protection Supervisor

This block is the control sequencer for a three-phase polygon-mirror spindle driver. It takes an active-low run request, single-cycle pulses that mark reference clock edges and rising FG edges, and a slow timebase tick. From these it decides whether the power stage may drive, whether the drive should be pulsed intermittently, and when the downstream control logic is held in its start-up reset. Every protection window is measured in timebase ticks, not in system clocks.

A start request first holds the control logic in reset for a set number of ticks, and only then enables drive. While the motor is running, two timers watch it. A missing reference clock drops the block into an intermittent mode that pulses drive on and off every tick until a reference edge comes back. A stalled rotor, meaning no FG edge for a set number of ticks, shuts the drive off and latches that shutdown. The latch clears only when stop is requested or the block is reset. Thermal and undervoltage fault levels gate the drive off while they are asserted and do not latch. The run request is expected to be pulled up outside the block, so an undriven request reads as stop. All inputs are synchronous to `clk`.

Top module: `spindle_supervisor`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `state_o` is 0 (stop) and `drive_en`, `intermit` and `logic_rst` are all 0. The state codes are: stop=0, reset=1, run=2, clock-lost=3, locked-out=4.
- R2: When `run_req_n` is 1 at a clock edge, `state_o` is 0 after that edge from any state, and `drive_en` is 0. This takes priority over any timeout that expires in the same cycle.
- R3: In stop, `run_req_n`=0 moves the state to reset (1) at the next edge. In reset, `logic_rst`=1 and `drive_en`=0. The RESET_TICKS-th tick seen in reset (default 4) moves the state to run (2).
- R4: In run with no fault, `drive_en`=1, `intermit`=0 and `logic_rst`=0.
- R5: While `therm_fault` or `uv_fault` is 1, `drive_en` is 0 in that same cycle. The state is not changed, and drive returns as soon as both faults are 0.
- R6: In run, if CLKLOSS_TICKS ticks (default 2) arrive without a `ref_edge`, the state moves to clock-lost (3). A `ref_edge` restarts that count, including one that coincides with a tick.
- R7: In clock-lost, `intermit`=1. `drive_en` is 1 from entry until the first tick and then inverts on every tick (gated by R5).
- R8: In clock-lost, a `ref_edge` returns the state to run at the next edge, unless the rotor timeout expires in the same cycle.
- R9: In run or clock-lost, if CONSTRAINT_TICKS ticks (default 31) arrive without an `fg_edge`, the state moves to locked-out (4) with all outputs 0. An `fg_edge` restarts the count. The count starts from zero on entry to run from reset.
- R10: Locked-out ignores `ref_edge`, `fg_edge` and ticks. It is left only through R2 or `rst`. After a stop, a new start goes through reset again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_req_n | input | 1 | Run request, 0 = start, 1 = stop |
| ref_edge | input | 1 | One-cycle pulse per reference clock edge |
| fg_edge | input | 1 | One-cycle pulse per rising FG edge |
| tb_tick | input | 1 | One-cycle pulse per timebase period |
| therm_fault | input | 1 | Over-temperature level, gates drive |
| uv_fault | input | 1 | Undervoltage level, gates drive |
| drive_en | output | 1 | Power stage enable |
| intermit | output | 1 | Intermittent drive mode flag |
| logic_rst | output | 1 | Start-up reset to the control logic |
| state_o | output | 3 | Current supervisor state code |

## Verification
A state change and the outputs it implies are due one clock edge after the input that causes it. A timeout is due one edge after the tick that completes the window. Fault gating of `drive_en` is combinational, so it shows in the same cycle as the fault. The bench changes inputs on the falling edge and holds them through the next rising edge. It samples one nanosecond after that rising edge, while the inputs are still applied, so every check sees exactly one new state together with the fault levels that gate it. The timeout windows are checked one tick short of expiry and again at expiry.

// File: rtl/spsup_pkg.sv
package spsup_pkg;

    typedef enum logic [2:0] {
        SUP_STOP     = 3'd0,
        SUP_RESET    = 3'd1,
        SUP_RUN      = 3'd2,
        SUP_CLK_LOST = 3'd3,
        SUP_LOCKED   = 3'd4
    } sup_state_e;

    // Expiry pulses from the three tick timers
    typedef struct packed {
        logic rst_done;
        logic clk_lost;
        logic fg_stall;
    } sup_timeouts_t;

    // Decoded outputs
    typedef struct packed {
        logic drive_en;
        logic intermit;
        logic logic_rst;
    } sup_outs_t;

    // Counter width able to hold 0 .. lim-1
    function automatic int unsigned cnt_width(input int unsigned lim);
        return (lim < 3) ? 1 : $clog2(lim);
    endfunction

endpackage

// File: rtl/spsup_tick_timer.sv
module spsup_tick_timer #(
    parameter int unsigned LIMIT = 31
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic restart,
    input  logic tick,
    output logic expire
);
    import spsup_pkg::*;

    localparam int unsigned W = cnt_width(LIMIT);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !enable || restart) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Fires on the LIMIT-th tick with no restart in between
    assign expire = enable && !restart && tick && (cnt_q == LAST);

endmodule

// File: rtl/spsup_fsm.sv
module spsup_fsm (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     run_req_n,
    input  logic                     ref_edge,
    input  spsup_pkg::sup_timeouts_t tmo,
    output spsup_pkg::sup_state_e    state
);
    import spsup_pkg::*;

    sup_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (run_req_n) begin
            state_d = SUP_STOP;
        end else begin
            unique case (state_q)
                SUP_STOP:     state_d = SUP_RESET;
                SUP_RESET:    if (tmo.rst_done) state_d = SUP_RUN;
                SUP_RUN: begin
                    if (tmo.fg_stall)      state_d = SUP_LOCKED;
                    else if (tmo.clk_lost) state_d = SUP_CLK_LOST;
                end
                SUP_CLK_LOST: begin
                    if (tmo.fg_stall)  state_d = SUP_LOCKED;
                    else if (ref_edge) state_d = SUP_RUN;
                end
                SUP_LOCKED:   state_d = SUP_LOCKED;
                default:      state_d = SUP_STOP;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SUP_STOP;
        else     state_q <= state_d;
    end

    assign state = state_q;

endmodule

// File: rtl/spsup_drive_gate.sv
module spsup_drive_gate (
    input  logic                  clk,
    input  logic                  rst,
    input  spsup_pkg::sup_state_e state,
    input  logic                  tick,
    input  logic                  fault,
    output spsup_pkg::sup_outs_t  outs
);
    import spsup_pkg::*;

    logic phase_q;

    // Intermittent phase: on at entry, flips each tick while clock is lost
    always_ff @(posedge clk) begin
        if (rst || state != SUP_CLK_LOST) phase_q <= 1'b1;
        else if (tick)                    phase_q <= ~phase_q;
    end

    always_comb begin
        outs = '0;
        unique case (state)
            SUP_RESET:    outs.logic_rst = 1'b1;
            SUP_RUN:      outs.drive_en  = ~fault;
            SUP_CLK_LOST: begin
                outs.intermit = 1'b1;
                outs.drive_en = phase_q & ~fault;
            end
            default:      outs = '0;
        endcase
    end

endmodule

// File: rtl/spindle_supervisor.sv
module spindle_supervisor #(
    parameter int unsigned RESET_TICKS      = 4,
    parameter int unsigned CLKLOSS_TICKS    = 2,
    parameter int unsigned CONSTRAINT_TICKS = 31
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run_req_n,
    input  logic       ref_edge,
    input  logic       fg_edge,
    input  logic       tb_tick,
    input  logic       therm_fault,
    input  logic       uv_fault,
    output logic       drive_en,
    output logic       intermit,
    output logic       logic_rst,
    output logic [2:0] state_o
);
    import spsup_pkg::*;

    sup_state_e    state;
    sup_timeouts_t tmo;
    sup_outs_t     outs;

    spsup_tick_timer #(.LIMIT(RESET_TICKS)) u_rst_tmr (
        .clk(clk), .rst(rst),
        .enable(state == SUP_RESET), .restart(1'b0),
        .tick(tb_tick), .expire(tmo.rst_done)
    );

    spsup_tick_timer #(.LIMIT(CLKLOSS_TICKS)) u_clk_tmr (
        .clk(clk), .rst(rst),
        .enable(state == SUP_RUN), .restart(ref_edge),
        .tick(tb_tick), .expire(tmo.clk_lost)
    );

    spsup_tick_timer #(.LIMIT(CONSTRAINT_TICKS)) u_fg_tmr (
        .clk(clk), .rst(rst),
        .enable(state == SUP_RUN || state == SUP_CLK_LOST), .restart(fg_edge),
        .tick(tb_tick), .expire(tmo.fg_stall)
    );

    spsup_fsm u_fsm (
        .clk(clk), .rst(rst), .run_req_n(run_req_n),
        .ref_edge(ref_edge), .tmo(tmo), .state(state)
    );

    spsup_drive_gate u_gate (
        .clk(clk), .rst(rst), .state(state), .tick(tb_tick),
        .fault(therm_fault | uv_fault), .outs(outs)
    );

    assign drive_en  = outs.drive_en;
    assign intermit  = outs.intermit;
    assign logic_rst = outs.logic_rst;
    assign state_o   = state;

endmodule

// File: rtl/spsup_checker.sv
module spsup_checker (
    input logic       clk,
    input logic       rst,
    input logic       run_req_n,
    input logic       ref_edge,
    input logic       fg_edge,
    input logic       therm_fault,
    input logic       uv_fault,
    input logic       drive_en,
    input logic       intermit,
    input logic       logic_rst,
    input logic [2:0] state_o
);
    AST_STOP_WINS: assert property (@(posedge clk) disable iff (rst)
        run_req_n |=> (state_o == 3'd0 && !drive_en)); // R2
    AST_START_ENTERS_RESET: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd0 && !run_req_n) |=> state_o == 3'd1); // R3
    AST_RESET_HOLDS_LOGIC: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd1) |-> (logic_rst && !drive_en)); // R3
    AST_FAULT_GATES_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (therm_fault || uv_fault) |-> !drive_en); // R5
    AST_INTERMIT_ONLY_LOST: assert property (@(posedge clk) disable iff (rst)
        intermit |-> state_o == 3'd3); // R7
    AST_REF_RESTORES_RUN: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd3 && !run_req_n && ref_edge && fg_edge) |=> state_o == 3'd2); // R8
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        (state_o == 3'd4 && !run_req_n) |=> (state_o == 3'd4 && !drive_en)); // R10
endmodule

bind spindle_supervisor spsup_checker u_chk (
    .clk(clk), .rst(rst), .run_req_n(run_req_n), .ref_edge(ref_edge),
    .fg_edge(fg_edge), .therm_fault(therm_fault), .uv_fault(uv_fault),
    .drive_en(drive_en), .intermit(intermit), .logic_rst(logic_rst),
    .state_o(state_o)
);

// File: tb/spindle_supervisor_test.sv
`timescale 1ns/1ps
module spindle_supervisor_test;
    logic clk = 1'b0;
    logic rst, run_req_n, ref_edge, fg_edge, tb_tick, therm_fault, uv_fault;
    logic drive_en, intermit, logic_rst;
    logic [2:0] state_o;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    spindle_supervisor uut (
        .clk(clk), .rst(rst), .run_req_n(run_req_n), .ref_edge(ref_edge),
        .fg_edge(fg_edge), .tb_tick(tb_tick), .therm_fault(therm_fault),
        .uv_fault(uv_fault), .drive_en(drive_en), .intermit(intermit),
        .logic_rst(logic_rst), .state_o(state_o)
    );

    // {run_n, ref, fg, tick, therm, uv, state[2:0], drive, intermit, logic_rst}
    localparam int NV = 20;
    localparam logic [11:0] VEC [NV] = '{
        12'b100000_000_000, 12'b000000_001_001, 12'b000100_001_001,
        12'b000100_001_001, 12'b000100_001_001, 12'b000100_010_100,
        12'b011100_010_100, 12'b001100_010_100, 12'b010000_010_100,
        12'b010010_010_000, 12'b000001_010_000, 12'b000000_010_100,
        12'b001100_010_100, 12'b001100_011_110, 12'b001100_011_010,
        12'b001100_011_110, 12'b000000_011_110, 12'b000010_011_010,
        12'b010000_010_100, 12'b100000_000_000
    };

    function automatic string vec_tag(input int i);
        case (i)
            0:             return "R1";
            1, 2, 3, 4:    return "R3";
            5:             return "R4";
            9, 10, 11:     return "R5";
            14, 15, 16, 17: return "R7";
            18:            return "R8";
            19:            return "R2";
            default:       return "R6";
        endcase
    endfunction

    task automatic apply(input logic rn, input logic rf, input logic fg,
                         input logic tk, input logic th, input logic uv);
        @(negedge clk);
        run_req_n = rn; ref_edge = rf; fg_edge = fg;
        tb_tick = tk; therm_fault = th; uv_fault = uv;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [2:0] st, input logic dr,
                       input logic im, input logic lr);
        checks++;
        if (state_o !== st || drive_en !== dr || intermit !== im || logic_rst !== lr) begin
            errors++;
            $display("FAIL %s: got st=%0d dr=%0b im=%0b lr=%0b, expected st=%0d dr=%0b im=%0b lr=%0b",
                     tag, state_o, drive_en, intermit, logic_rst, st, dr, im, lr);
        end
    endtask

    task automatic start_to_run();
        apply(0, 0, 0, 0, 0, 0);
        repeat (4) apply(0, 0, 0, 1, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got no finish, expected finish before timeout");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        rst = 1'b1; run_req_n = 1'b1; ref_edge = 1'b0; fg_edge = 1'b0;
        tb_tick = 1'b0; therm_fault = 1'b0; uv_fault = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 in reset", 3'd0, 0, 0, 0);
        @(negedge clk) rst = 1'b0;

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6]);
            chk(vec_tag(i), VEC[i][5:3], VEC[i][2], VEC[i][1], VEC[i][0]);
        end

        // R6: a ref edge in the same cycle as a tick restarts the loss count
        start_to_run();
        chk("R3 run after reset ticks", 3'd2, 1, 0, 0);
        apply(0, 0, 1, 1, 0, 0);
        apply(0, 1, 1, 1, 0, 0);
        chk("R6 ref+tick restart", 3'd2, 1, 0, 0);
        apply(0, 0, 1, 1, 0, 0);
        chk("R6 one tick after restart", 3'd2, 1, 0, 0);

        // R9: FG stall in run
        for (int k = 0; k < 30; k++) apply(0, 1, 0, 1, 0, 0);
        chk("R9 one tick short", 3'd2, 1, 0, 0);
        apply(0, 1, 0, 1, 0, 0);
        chk("R9 stall in run", 3'd4, 0, 0, 0);

        // R10: latched until stop
        repeat (3) apply(0, 1, 1, 1, 0, 0);
        chk("R10 edges ignored", 3'd4, 0, 0, 0);
        apply(1, 0, 0, 0, 0, 0);
        chk("R10 stop clears", 3'd0, 0, 0, 0);
        apply(0, 0, 0, 0, 0, 0);
        chk("R10 restart enters reset", 3'd1, 0, 0, 1);

        // Clock absent at start: intermittent, then stall latches
        repeat (4) apply(0, 0, 0, 1, 0, 0);
        apply(0, 0, 1, 1, 0, 0);
        apply(0, 0, 1, 1, 0, 0);
        chk("R6 no clock at start", 3'd3, 1, 1, 0);
        for (int k = 0; k < 30; k++) apply(0, 0, 0, 1, 0, 0);
        chk("R7 after 30 toggles", 3'd3, 1, 1, 0);
        apply(0, 0, 0, 1, 0, 0);
        chk("R9 stall in clock-lost", 3'd4, 0, 0, 0);
        apply(0, 1, 0, 0, 0, 0);
        chk("R10 late clock ignored", 3'd4, 0, 0, 0);

        // R2: stop beats a stall expiring in the same cycle
        apply(1, 0, 0, 0, 0, 0);
        start_to_run();
        for (int k = 0; k < 30; k++) apply(0, 1, 0, 1, 0, 0);
        apply(1, 1, 0, 1, 0, 0);
        chk("R2 stop over stall", 3'd0, 0, 0, 0);

        // R1: reset while running
        start_to_run();
        @(negedge clk) begin rst = 1'b1; run_req_n = 1'b1; end
        @(posedge clk);
        #1;
        chk("R1 reset mid-run", 3'd0, 0, 0, 0);
        @(negedge clk) rst = 1'b0;
        @(posedge clk);
        #1;
        chk("R1 after reset release", 3'd0, 0, 0, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule